// File: doc/BRIEF.md
# Software Interrupt Dispatcher

This block turns one 32-bit write to a software-trigger register into pending software interrupts for a set of CPU targets. The written word carries an interrupt number in its low four bits. A two-bit routing mode in bits [25:24] decides how destinations are chosen. The mode can use an explicit target mask, or it can send to every CPU except the writer, or it can send only back to the writer. Bit 15 carries a security attribute, which the block stores with each pending entry.

Each target CPU keeps its own set of pending entries. Every entry is identified by the pair (interrupt number, source CPU), so the same number raised by two different CPUs stays as two entries. For each target the block reports one pending entry through a 12-bit info word: the interrupt ID in bits [9:0] and the source CPU in bits [11:10]. The target's acknowledge strobe removes that reported entry. The reported entry is the lowest interrupt number, and among entries with that number the lowest source CPU.

A write updates the pending state at the next rising clock edge. The report outputs are driven by combinational logic from the registered state, so a new entry is visible in the cycle after the write.

Top module: `sgi_dispatch`

## Requirements
- R1: The interrupt number is taken from write-data bits [3:0]. It is reported zero-extended in bits [9:0] of the target's 12-bit info word, in the cycle after the write.
- R2: With routing mode 00, target n receives the interrupt exactly when write-data bit 16+n is set. List bits for CPUs at or above NUM_CPU have no effect.
- R3: With routing mode 01, every target except the writing CPU receives the interrupt, and the target list is ignored.
- R4: With routing mode 10, only the writing CPU receives the interrupt, and the target list is ignored.
- R5: With routing mode 11, the write sets no pending entry on any target.
- R6: The CPU that made the write is reported in bits [11:10] of the info word.
- R7: The same interrupt number written by different source CPUs to one target is held as separate entries. Each entry is reported and acknowledged on its own.
- R8: When several entries are pending for a target, the lowest interrupt number is reported first, then the lowest source CPU. The report stays steady while no write or acknowledge occurs.
- R9: An acknowledge removes only the reported entry of that target, effective in the next cycle. An acknowledge while nothing is pending for that target has no effect.
- R10: When a write sets the entry being acknowledged in the same cycle, the entry stays pending.
- R11: irq_ns reports write-data bit 15 of the most recent write that set the reported entry (1 = non-secure, 0 = secure).
- R12: After reset no target has a pending entry, and irq_pend, irq_info and irq_ns are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the trigger word |
| wr_data | input | 32 | Trigger word: [3:0] number, [15] attribute, [23:16] target list, [25:24] routing mode |
| wr_cpu | input | $clog2(NUM_CPU) | ID of the CPU making the write |
| ack | input | NUM_CPU | Per-target acknowledge of the reported entry |
| irq_pend | output | NUM_CPU | Per-target: at least one entry pending |
| irq_info | output | 12*NUM_CPU | Per-target report; target t at [12t+11:12t]: [9:0] ID, [11:10] source |
| irq_ns | output | NUM_CPU | Per-target stored attribute of the reported entry |

## Verification
A fault in the pending matrix shows up at the ports in the cycle after the write that touched it. The fault appears as a wrong irq_pend mask or a wrong info word on one target. If the fault is in the ordering or in the clear-on-acknowledge logic, it may stay hidden until earlier entries have been drained. For that reason the bench acknowledges entries one at a time and checks every report in the sequence until the target is empty. A lost or merged entry then shows up as a short or wrong sequence.

// File: rtl/sgi_dispatch_pkg.sv
package sgi_dispatch_pkg;
    // trigger word fields
    localparam int SGI_W     = 4;
    localparam int TLIST_LSB = 16;
    localparam int TLIST_W   = 8;
    localparam int MODE_LSB  = 24;
    localparam int ATTR_BIT  = 15;
    // report word fields
    localparam int INFO_W    = 12;
    localparam int ID_W      = 10;
    localparam int SRC_W     = 2;

    typedef enum logic [1:0] {
        ROUTE_LIST   = 2'b00,
        ROUTE_OTHERS = 2'b01,
        ROUTE_SELF   = 2'b10,
        ROUTE_NONE   = 2'b11
    } route_e;
endpackage

// File: rtl/sgi_req_decode.sv
module sgi_req_decode
    import sgi_dispatch_pkg::*;
#(
    parameter int NUM_CPU = 4,
    localparam int CPU_W  = $clog2(NUM_CPU),
    localparam int ENT_W  = SGI_W + CPU_W
) (
    input  logic               wr_en,
    input  logic [31:0]        wr_data,
    input  logic [CPU_W-1:0]   wr_cpu,
    output logic [NUM_CPU-1:0] set_mask,
    output logic [ENT_W-1:0]   set_idx,
    output logic               set_ns
);
    logic [NUM_CPU-1:0] self_mask;
    route_e             mode;

    always_comb begin
        mode      = route_e'(wr_data[MODE_LSB +: 2]);
        self_mask = NUM_CPU'(1) << wr_cpu;
        unique case (mode)
            ROUTE_LIST:   set_mask = wr_data[TLIST_LSB +: NUM_CPU];
            ROUTE_OTHERS: set_mask = ~self_mask;
            ROUTE_SELF:   set_mask = self_mask;
            default:      set_mask = '0;
        endcase
        if (!wr_en) begin
            set_mask = '0;
        end
        // entry index: number in the high bits, source in the low bits
        set_idx = {wr_data[SGI_W-1:0], wr_cpu};
        set_ns  = wr_data[ATTR_BIT];
    end
endmodule

// File: rtl/sgi_pick.sv
module sgi_pick #(
    parameter int ENT_W   = 6,
    localparam int NUM_ENT = 1 << ENT_W
) (
    input  logic [NUM_ENT-1:0] vec,
    output logic               found,
    output logic [ENT_W-1:0]   idx
);
    // lowest set index wins: lowest number, then lowest source
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_ENT - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = ENT_W'(i);
            end
        end
    end
endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
    import sgi_dispatch_pkg::*;
#(
    parameter int NUM_CPU = 4,
    localparam int CPU_W   = $clog2(NUM_CPU),
    localparam int ENT_W   = SGI_W + CPU_W,
    localparam int NUM_ENT = 1 << ENT_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [31:0]               wr_data,
    input  logic [CPU_W-1:0]          wr_cpu,
    input  logic [NUM_CPU-1:0]        ack,
    output logic [NUM_CPU-1:0]        irq_pend,
    output logic [INFO_W*NUM_CPU-1:0] irq_info,
    output logic [NUM_CPU-1:0]        irq_ns
);
    typedef struct packed {
        logic [NUM_CPU-1:0][NUM_ENT-1:0] pend;
        logic [NUM_CPU-1:0][NUM_ENT-1:0] ns;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_CPU-1:0] set_mask;
    logic [ENT_W-1:0]   set_idx;
    logic               set_ns;
    logic [NUM_CPU-1:0] found;
    logic [ENT_W-1:0]   pick_idx [NUM_CPU];

    sgi_req_decode #(.NUM_CPU(NUM_CPU)) u_decode (
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .wr_cpu   (wr_cpu),
        .set_mask (set_mask),
        .set_idx  (set_idx),
        .set_ns   (set_ns)
    );

    for (genvar t = 0; t < NUM_CPU; t++) begin : g_tgt
        sgi_pick #(.ENT_W(ENT_W)) u_pick (
            .vec   (st_q.pend[t]),
            .found (found[t]),
            .idx   (pick_idx[t])
        );
        assign irq_pend[t] = found[t];
        assign irq_ns[t]   = found[t] & st_q.ns[t][pick_idx[t]];
        assign irq_info[t*INFO_W +: INFO_W] = found[t] ?
            {SRC_W'(pick_idx[t][CPU_W-1:0]), ID_W'(pick_idx[t][ENT_W-1 -: SGI_W])} :
            '0;
    end

    always_comb begin
        st_d = st_q;
        for (int t = 0; t < NUM_CPU; t++) begin
            if (ack[t] && found[t]) begin
                st_d.pend[t][pick_idx[t]] = 1'b0;
            end
            // a same-cycle set overrides the clear
            if (set_mask[t]) begin
                st_d.pend[t][set_idx] = 1'b1;
                st_d.ns[t][set_idx]   = set_ns;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/sgi_dispatch_chk.sv
module sgi_dispatch_chk #(
    parameter int NUM_CPU = 4,
    localparam int CPU_W  = $clog2(NUM_CPU)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   wr_en,
    input logic [31:0]            wr_data,
    input logic [CPU_W-1:0]       wr_cpu,
    input logic [NUM_CPU-1:0]     ack,
    input logic [NUM_CPU-1:0]     irq_pend,
    input logic [12*NUM_CPU-1:0]  irq_info,
    input logic [NUM_CPU-1:0]     irq_ns
);
    AST_RSVD_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pend == '0 && wr_en && wr_data[25:24] == 2'b11) |=> irq_pend == '0); // R5

    AST_SELF_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pend == '0 && wr_en && wr_data[25:24] == 2'b10)
        |=> irq_pend == (NUM_CPU'(1) << $past(wr_cpu))); // R4

    AST_ALL_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pend == '0 && wr_en && wr_data[25:24] == 2'b01)
        |=> irq_pend == ~(NUM_CPU'(1) << $past(wr_cpu))); // R3

    AST_IDLE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pend == '0 && !wr_en) |=> irq_pend == '0); // R9

    for (genvar t = 0; t < NUM_CPU; t++) begin : g_hold
        AST_REPORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_pend[t] && !ack[t] && !wr_en)
            |=> ($stable(irq_info[t*12 +: 12]) && irq_pend[t])); // R8
    end
endmodule

bind sgi_dispatch sgi_dispatch_chk #(.NUM_CPU(NUM_CPU)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .wr_cpu   (wr_cpu),
    .ack      (ack),
    .irq_pend (irq_pend),
    .irq_info (irq_info),
    .irq_ns   (irq_ns)
);

// File: tb/sgi_dispatch_bench.sv
module sgi_dispatch_bench;
    localparam int NC = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [31:0]   wr_data = '0;
    logic [1:0]    wr_cpu = '0;
    logic [NC-1:0] ack = '0;
    logic [NC-1:0] irq_pend;
    logic [12*NC-1:0] irq_info;
    logic [NC-1:0] irq_ns;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sgi_dispatch #(.NUM_CPU(NC)) u_sgi_dispatch (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_cpu(wr_cpu), .ack(ack), .irq_pend(irq_pend),
        .irq_info(irq_info), .irq_ns(irq_ns)
    );

    // {write word, writer, expected pending mask}
    localparam logic [37:0] VEC [8] = '{
        {32'h0003_0005, 2'd0, 4'b0011},   // R2 list
        {32'h00F0_0007, 2'd1, 4'b0000},   // R2 list bits past NC
        {32'h010F_0002, 2'd2, 4'b1011},   // R3
        {32'h0200_000A, 2'd3, 4'b1000},   // R4
        {32'h03FF_0001, 2'd1, 4'b0000},   // R5
        {32'h000C_800F, 2'd1, 4'b1100},   // R2 with attribute set
        {32'h0100_0000, 2'd0, 4'b1110},   // R3
        {32'h0200_8003, 2'd0, 4'b0001}    // R4
    };

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_write(input logic [31:0] d, input logic [1:0] c);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; wr_cpu = c;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic do_ack(input logic [NC-1:0] m);
        @(negedge clk);
        ack = m;
        @(negedge clk);
        ack = '0;
    endtask

    function automatic logic [11:0] info_of(input int t);
        return irq_info[t*12 +: 12];
    endfunction

    function automatic logic [11:0] exp_info(input logic [1:0] src, input logic [3:0] id);
        return {src, 6'b0, id};
    endfunction

    initial begin
        #500_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R12 reset state
        #1;
        check(32'(irq_pend), 0, "R12 pend in reset");
        do_reset();
        check(32'(irq_pend), 0, "R12 pend after reset");
        check(32'(irq_info), 0, "R12 info after reset");
        check(32'(irq_ns), 0, "R12 ns after reset");

        // table walk: R1 R2 R3 R4 R5 R6 R11
        foreach (VEC[i]) begin
            do_reset();
            do_write(VEC[i][37:6], VEC[i][5:4]);
            check(32'(irq_pend), 32'(VEC[i][3:0]), $sformatf("R2-5 mask vec %0d", i));
            for (int t = 0; t < NC; t++) begin
                if (VEC[i][t]) begin
                    check(32'(info_of(t)), 32'(exp_info(VEC[i][5:4], VEC[i][9:6])),
                          $sformatf("R1 R6 info vec %0d tgt %0d", i, t));
                    check(32'(irq_ns[t]), 32'(VEC[i][6+15]), $sformatf("R11 ns vec %0d", i));
                end
            end
        end

        // R7 R8 ordering on target 0
        do_reset();
        do_write(32'h0001_0006, 2'd2);
        do_write(32'h0001_0006, 2'd1);
        do_write(32'h0001_0009, 2'd0);
        do_write(32'h0001_0003, 2'd3);
        check(32'(info_of(0)), 32'(exp_info(2'd3, 4'd3)), "R8 first");
        do_ack(4'b0001);
        check(32'(info_of(0)), 32'(exp_info(2'd1, 4'd6)), "R8 second");
        do_ack(4'b0001);
        check(32'(info_of(0)), 32'(exp_info(2'd2, 4'd6)), "R7 separate source");
        // R9 ack on an empty target leaves target 0 untouched
        do_ack(4'b0010);
        check(32'(irq_pend), 32'h1, "R9 empty ack mask");
        check(32'(info_of(0)), 32'(exp_info(2'd2, 4'd6)), "R9 empty ack info");
        do_ack(4'b0001);
        check(32'(info_of(0)), 32'(exp_info(2'd0, 4'd9)), "R9 fourth");
        do_ack(4'b0001);
        check(32'(irq_pend), 0, "R9 drained");

        // R10 same-cycle set wins over ack
        do_write(32'h0001_0005, 2'd0);
        @(negedge clk);
        ack = 4'b0001; wr_en = 1'b1; wr_data = 32'h0001_0005; wr_cpu = 2'd0;
        @(negedge clk);
        ack = '0; wr_en = 1'b0; wr_data = '0;
        check(32'(irq_pend), 32'h1, "R10 still pending");
        check(32'(info_of(0)), 32'(exp_info(2'd0, 4'd5)), "R10 info");
        do_ack(4'b0001);
        check(32'(irq_pend), 0, "R10 cleared after");

        // R11 attribute overwritten by later write
        do_write(32'h0001_8004, 2'd0);
        check(32'(irq_ns), 32'h1, "R11 ns set");
        do_write(32'h0001_0004, 2'd0);
        check(32'(irq_ns), 32'h0, "R11 ns overwritten");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule